// File: doc/BRIEF.md
# ADC Event Interrupt and DMA Request Controller

This block sits beside an analog-to-digital converter sequencer. It turns the sequencer's one-cycle event pulses into sticky pending flags, and from those flags into one masked interrupt line and a set of per-channel DMA request lines. The event pulses come in several kinds: per-channel conversion done, end of a normal chain, injected conversion and injected chain completion, a reference-range fault, high and low threshold crossings from four analog watchdogs, and self-test completion and end-of-algorithm. Software reaches the flags and masks through a simple word-addressed register bus. Pending flags are cleared by writing ones to them. Mask and control registers are plain read/write.

Each channel can be selected for DMA. A selected channel's conversion leaves a DMA request pending, and that request is visible at the outputs only while the global DMA enable is set. A request can be retired in two ways: by a write-one-to-clear, or, when clear-on-read is enabled, by a read of that channel's result register. That read is reported to this block on the `res_rd`/`res_rd_ch` inputs.

Register map (word address on `bus_addr`). The bus read is combinational.
- 0 global flags, write 1 to clear. Bits: 0 conversion done, 1 chain done, 2 injected conversion done, 3 injected chain done, 4 reference fault, 5 self-test channel done, 6 self-test algorithm done.
- 1 global mask, same bit positions.
- 2 channel pending flags, write 1 to clear. Bit i is channel i.
- 3 channel mask. Bit i is channel i.
- 4 watchdog pending flags, write 1 to clear. Bit 2k is the low threshold of watchdog k and bit 2k+1 is its high threshold.
- 5 watchdog mask, same bit positions.
- 6 DMA control. Bit 0 is the global enable and bit 1 is clear-on-read.
- 7 DMA channel select. Bit i is channel i.
- 8 DMA pending, write 1 to clear. Bit i is channel i.

Top module: `adc_event_irq_ctrl`

## Requirements
- R1: After reset every register at addresses 0 to 8 reads 0, `irq` is 0 and `dma_req` is 0.
- R2: A pulse on `ch_done[i]` sets bit i of the channel pending register (address 2) and bit 0 of the global flags (address 0). Both are visible one cycle after the pulse.
- R3: Writing a word to address 0, 2, 4 or 8 clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: When an event and a write-one-to-clear hit the same flag in the same cycle, the flag stays set.
- R5: `irq` is a registered output. It is 1 exactly one cycle after any pending flag is set together with its mask bit. The masks are global at address 1, channel at address 3 and watchdog at address 5.
- R6: `wd_lo[k]` sets watchdog pending bit 2k and `wd_hi[k]` sets bit 2k+1. Each of these bits is masked on its own.
- R7: `chain_done`, `inj_done`, `inj_chain_done` and `ref_fault` set global flag bits 1, 2, 3 and 4 respectively.
- R8: `st_done` sets global flag bits 0, 1 and 5. `st_algo_done` sets global flag bit 6.
- R9: A pulse on `ch_done[i]` while DMA select bit i is 1 sets DMA pending bit i. A pulse on an unselected channel does not set it.
- R10: `dma_req` equals the DMA pending register while DMA control bit 0 is 1, and is 0 while that bit is 0. Pending bits are kept while the enable is 0.
- R11: With DMA control bit 1 set, a pulse on `res_rd` clears DMA pending bit `res_rd_ch`. With bit 1 clear, `res_rd` has no effect.
- R12: Clearing a DMA select bit does not drop a DMA request that is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_done | input | NCH | Per-channel conversion-done pulses |
| chain_done | input | 1 | Normal chain complete pulse |
| inj_done | input | 1 | Injected conversion complete pulse |
| inj_chain_done | input | 1 | Injected chain complete pulse |
| ref_fault | input | 1 | Reference-range fault pulse |
| wd_lo | input | NWD | Watchdog low-threshold crossing pulses |
| wd_hi | input | NWD | Watchdog high-threshold crossing pulses |
| st_done | input | 1 | Self-test channel complete pulse |
| st_algo_done | input | 1 | Self-test algorithm complete pulse |
| res_rd | input | 1 | Result register of a channel was read |
| res_rd_ch | input | $clog2(NCH) | Channel whose result was read |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Registered interrupt request |
| dma_req | output | NCH | Per-channel DMA requests |

## Verification
The bench sweeps every channel mask value against every single pending channel. A design that ignored a mask bit, or that tied `irq` to the wrong bit, would therefore show a wrong `irq` in at least one combination. It collides a write-one-to-clear with a new event in the same cycle. A design that gave the clear priority would lose that event. The bench also checks that the low and high watchdog bits of every watchdog land in their own positions, so a design with the pair swapped is caught. It toggles the DMA enable, drops the select bit under a pending request, and issues result reads with and without clear-on-read. A design that stored the request gated by the enable, re-derived it from the select bit, or cleared it on any read would show the wrong `dma_req`.

// File: rtl/adc_event_irq_ctrl.sv
module adc_event_irq_ctrl #(
  parameter int NCH = 8,
  parameter int NWD = 4,
  parameter int DW  = 32,
  parameter int AW  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         ch_done,
  input  logic                   chain_done,
  input  logic                   inj_done,
  input  logic                   inj_chain_done,
  input  logic                   ref_fault,
  input  logic [NWD-1:0]         wd_lo,
  input  logic [NWD-1:0]         wd_hi,
  input  logic                   st_done,
  input  logic                   st_algo_done,
  input  logic                   res_rd,
  input  logic [$clog2(NCH)-1:0] res_rd_ch,
  input  logic                   bus_wr,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  output logic                   irq,
  output logic [NCH-1:0]         dma_req
);
  localparam int GW = 7;
  localparam int WW = 2 * NWD;
  localparam logic [AW-1:0] A_GFLAG = AW'(0), A_GMASK = AW'(1), A_CHPEND = AW'(2),
                            A_CHMASK = AW'(3), A_WDPEND = AW'(4), A_WDMASK = AW'(5),
                            A_DMACTL = AW'(6), A_DMASEL = AW'(7), A_DMAPEND = AW'(8);

  logic [GW-1:0]  gflag, gmask, gset;
  logic [NCH-1:0] chpend, chmask, dma_sel, dma_pend, rd_clr;
  logic [WW-1:0]  wdpend, wdmask, wdset;
  logic           dma_en, dma_cor;
  logic           unused_bits;

  function automatic logic is_wr(input logic wr, input logic [AW-1:0] a, input logic [AW-1:0] t);
    return wr && (a == t);
  endfunction

  assign gset = {st_algo_done, st_done, ref_fault, inj_chain_done, inj_done,
                 chain_done | st_done, (|ch_done) | st_done};

  for (genvar k = 0; k < NWD; k++) begin : g_wd
    assign wdset[2*k]   = wd_lo[k];
    assign wdset[2*k+1] = wd_hi[k];
  end

  assign rd_clr      = (res_rd && dma_cor) ? (NCH'(1) << res_rd_ch) : '0;
  assign dma_req     = dma_pend & {NCH{dma_en}};
  assign unused_bits = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gflag    <= '0;
      gmask    <= '0;
      chpend   <= '0;
      chmask   <= '0;
      wdpend   <= '0;
      wdmask   <= '0;
      dma_en   <= 1'b0;
      dma_cor  <= 1'b0;
      dma_sel  <= '0;
      dma_pend <= '0;
      irq      <= 1'b0;
    end else begin
      gflag    <= (gflag & ~(is_wr(bus_wr, bus_addr, A_GFLAG) ? bus_wdata[GW-1:0] : '0)) | gset;
      chpend   <= (chpend & ~(is_wr(bus_wr, bus_addr, A_CHPEND) ? bus_wdata[NCH-1:0] : '0)) | ch_done;
      wdpend   <= (wdpend & ~(is_wr(bus_wr, bus_addr, A_WDPEND) ? bus_wdata[WW-1:0] : '0)) | wdset;
      dma_pend <= (dma_pend & ~rd_clr & ~(is_wr(bus_wr, bus_addr, A_DMAPEND) ? bus_wdata[NCH-1:0] : '0))
                  | (ch_done & dma_sel);
      if (is_wr(bus_wr, bus_addr, A_GMASK))  gmask   <= bus_wdata[GW-1:0];
      if (is_wr(bus_wr, bus_addr, A_CHMASK)) chmask  <= bus_wdata[NCH-1:0];
      if (is_wr(bus_wr, bus_addr, A_WDMASK)) wdmask  <= bus_wdata[WW-1:0];
      if (is_wr(bus_wr, bus_addr, A_DMASEL)) dma_sel <= bus_wdata[NCH-1:0];
      if (is_wr(bus_wr, bus_addr, A_DMACTL)) begin
        dma_en  <= bus_wdata[0];
        dma_cor <= bus_wdata[1];
      end
      irq <= (|(gflag & gmask)) | (|(chpend & chmask)) | (|(wdpend & wdmask));
    end
  end

  always_comb begin
    case (bus_addr)
      A_GFLAG:   bus_rdata = DW'(gflag);
      A_GMASK:   bus_rdata = DW'(gmask);
      A_CHPEND:  bus_rdata = DW'(chpend);
      A_CHMASK:  bus_rdata = DW'(chmask);
      A_WDPEND:  bus_rdata = DW'(wdpend);
      A_WDMASK:  bus_rdata = DW'(wdmask);
      A_DMACTL:  bus_rdata = DW'({dma_cor, dma_en});
      A_DMASEL:  bus_rdata = DW'(dma_sel);
      A_DMAPEND: bus_rdata = DW'(dma_pend);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_event_irq_chk.sv
module adc_event_irq_chk #(
  parameter int NCH = 8,
  parameter int NWD = 4,
  parameter int AW  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   ch_done,
  input logic [NWD-1:0]   wd_lo,
  input logic [NWD-1:0]   wd_hi,
  input logic             st_done,
  input logic             res_rd,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [6:0]       gflag,
  input logic [6:0]       gmask,
  input logic [NCH-1:0]   chpend,
  input logic [NCH-1:0]   chmask,
  input logic [2*NWD-1:0] wdpend,
  input logic [2*NWD-1:0] wdmask,
  input logic             dma_en,
  input logic             dma_cor,
  input logic [NCH-1:0]   dma_sel,
  input logic [NCH-1:0]   dma_pend,
  input logic [NCH-1:0]   dma_req,
  input logic             irq
);
  localparam logic [AW-1:0] A_DMAPEND = AW'(8);

  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_done) |=> ((chpend & $past(ch_done)) == $past(ch_done)) && gflag[0]);

  for (genvar k = 0; k < NWD; k++) begin : g_wd
    assert_wd_lo_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wd_lo[k] |=> wdpend[2*k]);
    assert_wd_hi_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wd_hi[k] |=> wdpend[2*k+1]);
  end

  assert_selftest_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |=> (gflag[0] && gflag[1] && gflag[5]));

  assert_dma_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && !bus_wr && |(ch_done & dma_sel))
      |=> ((dma_req & $past(ch_done & dma_sel)) == $past(ch_done & dma_sel)));

  assert_dma_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && bus_addr == A_DMAPEND) && !(res_rd && dma_cor))
      |=> ((dma_pend & $past(dma_pend)) == $past(dma_pend)));

  assert_irq_masked_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask == '0 && chmask == '0 && wdmask == '0) |=> !irq);
endmodule

bind adc_event_irq_ctrl adc_event_irq_chk #(.NCH(NCH), .NWD(NWD), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_done(ch_done), .wd_lo(wd_lo), .wd_hi(wd_hi),
  .st_done(st_done), .res_rd(res_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .gflag(gflag), .gmask(gmask), .chpend(chpend), .chmask(chmask),
  .wdpend(wdpend), .wdmask(wdmask), .dma_en(dma_en), .dma_cor(dma_cor),
  .dma_sel(dma_sel), .dma_pend(dma_pend), .dma_req(dma_req), .irq(irq));

// File: tb/tb_adc_event_irq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_event_irq_ctrl;
  localparam int NCH = 8, NWD = 4, DW = 32, AW = 4;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] ch_done = '0;
  logic chain_done = 0, inj_done = 0, inj_chain_done = 0, ref_fault = 0;
  logic [NWD-1:0] wd_lo = '0, wd_hi = '0;
  logic st_done = 0, st_algo_done = 0, res_rd = 0;
  logic [2:0] res_rd_ch = '0;
  logic bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic irq;
  logic [NCH-1:0] dma_req;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_event_irq_ctrl #(.NCH(NCH), .NWD(NWD), .DW(DW), .AW(AW)) dut (.*);

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    bus_addr = AW'(a);
    #0.5 d = bus_rdata;
  endtask

  task automatic settle;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all;
    wr(0, '1); wr(2, '1); wr(4, '1); wr(8, '1);
    wr(1, 0); wr(3, 0); wr(5, 0);
    settle();
  endtask

  logic [DW-1:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a <= 8; a++) begin rd(a, v); chk("R1 reg", v, 0); end
    chk("R1 irq", DW'(irq), 0);
    chk("R1 dma_req", DW'(dma_req), 0);

    for (int c = 0; c < NCH; c++) begin
      clear_all();
      @(negedge clk); ch_done = NCH'(1) << c;
      @(negedge clk); ch_done = '0;
      rd(2, v); chk("R2 chpend", v, DW'(1) << c);
      rd(0, v); chk("R2 gflag eoc", v, 1);
      for (int m = 0; m < 256; m++) begin
        wr(3, DW'(m));
        settle();
        chk("R5 irq vs chmask", DW'(irq), DW'((m >> c) & 1));
      end
    end

    clear_all();
    @(negedge clk); ch_done = '1;
    @(negedge clk); ch_done = '0;
    wr(2, 32'hA5);
    rd(2, v); chk("R3 w1c chpend", v, 32'h5A);
    wr(0, 32'h0);
    rd(0, v); chk("R3 w0 keeps gflag", v, 1);

    @(negedge clk);
    bus_wr = 1; bus_addr = AW'(2); bus_wdata = 32'hFF; ch_done = 8'h10;
    @(negedge clk);
    bus_wr = 0; ch_done = '0;
    rd(2, v); chk("R4 event beats clear", v, 32'h10);

    clear_all();
    wr(0, '1);
    settle();
    chk("R5 irq low when unmasked", DW'(irq), 0);

    for (int k = 0; k < NWD; k++) begin
      clear_all();
      @(negedge clk); wd_lo = NWD'(1) << k;
      @(negedge clk); wd_lo = '0;
      rd(4, v); chk("R6 wd low bit", v, DW'(1) << (2 * k));
      @(negedge clk); wd_hi = NWD'(1) << k;
      @(negedge clk); wd_hi = '0;
      rd(4, v); chk("R6 wd pair", v, DW'(3) << (2 * k));
      wr(5, DW'(1) << (2 * k));
      settle();
      chk("R6 irq low-threshold mask", DW'(irq), 1);
      wr(4, DW'(1) << (2 * k));
      settle();
      rd(4, v); chk("R6 hi kept after low clear", v, DW'(2) << (2 * k));
      chk("R6 hi masked off", DW'(irq), 0);
    end

    for (int b = 1; b <= 4; b++) begin
      clear_all();
      wr(0, '1);
      @(negedge clk);
      chain_done = (b == 1); inj_done = (b == 2); inj_chain_done = (b == 3); ref_fault = (b == 4);
      @(negedge clk);
      chain_done = 0; inj_done = 0; inj_chain_done = 0; ref_fault = 0;
      rd(0, v); chk("R7 global flag", v, DW'(1) << b);
      wr(1, 32'h7F & ~(32'h1 << b));
      settle();
      chk("R7 other masks no irq", DW'(irq), 0);
      wr(1, DW'(1) << b);
      settle();
      chk("R7 irq when masked in", DW'(irq), 1);
    end

    clear_all();
    wr(0, '1);
    @(negedge clk); st_done = 1;
    @(negedge clk); st_done = 0;
    rd(0, v); chk("R8 self-test done flags", v, 32'h23);
    wr(0, '1);
    @(negedge clk); st_algo_done = 1;
    @(negedge clk); st_algo_done = 0;
    rd(0, v); chk("R8 self-test algo flag", v, 32'h40);

    clear_all();
    wr(6, 1); wr(7, 32'h0F);
    @(negedge clk); ch_done = '1;
    @(negedge clk); ch_done = '0;
    chk("R9 dma selected only", DW'(dma_req), 32'h0F);
    wr(6, 0);
    chk("R10 dma_req gated", DW'(dma_req), 0);
    rd(8, v); chk("R10 pending kept", v, 32'h0F);
    wr(6, 1);
    chk("R10 reenabled", DW'(dma_req), 32'h0F);
    wr(7, 0);
    chk("R12 deselect keeps request", DW'(dma_req), 32'h0F);
    @(negedge clk); res_rd = 1; res_rd_ch = 3'd0;
    @(negedge clk); res_rd = 0;
    chk("R11 no clear without cor", DW'(dma_req), 32'h0F);
    wr(6, 3);
    @(negedge clk); res_rd = 1; res_rd_ch = 3'd2;
    @(negedge clk); res_rd = 0;
    chk("R11 clear on read ch2", DW'(dma_req), 32'h0B);
    wr(8, 32'h01);
    chk("R3 dma w1c", DW'(dma_req), 32'h0A);

    for (int c = 0; c < NCH; c++) begin
      wr(7, '1);
      @(negedge clk); ch_done = '1;
      @(negedge clk); ch_done = '0;
      @(negedge clk); res_rd = 1; res_rd_ch = 3'(c);
      @(negedge clk); res_rd = 0;
      chk("R11 clear on read sweep", DW'(dma_req), 32'hFF & ~(32'h1 << c));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule